// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Paired Condition Test

This block performs a two's-complement add or subtract on two operands and, when asked, evaluates one condition test on the outcome in the same operation. Rather than leaving condition codes behind in a flags register, the tested condition is handed back as a second, independent boolean result. Both results leave the block together, one clock after the request, under a common valid strobe. The boolean also carries its own valid bit.

A request names an arithmetic operation (add or subtract), an optional condition test and a 3-bit test selector. Any arithmetic operation may be combined with any test. The arithmetic value is exactly the same whether a test is attached or not. A test that arrives without an arithmetic operation is a malformed request. A selector code outside the defined set is also malformed. Either case raises a fault strobe instead of producing results.

Top module: `int_alu_gang`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid`, `out_flag_valid`, `out_fault`, `out_flag` and `out_result` are all 0.
- R2: For a cycle with `in_valid`=1 and `in_arith_en`=1 whose request is legal, `out_valid` is 1 on the next cycle and only then. `out_result` is `in_a + in_b` (when `in_sub`=0) or `in_a - in_b` (when `in_sub`=1), modulo 2^WIDTH.
- R3: `out_result` is bit-identical whether or not a condition test is attached, for every legal selector.
- R4: `out_flag_valid` is 1 exactly when `out_valid` is 1 and the accepted request had `in_pred_en`=1. When `out_flag_valid` is 0, `out_flag` is 0.
- R5: Selector codes: 0 = less-than (result bit WIDTH-1 is 1), 1 = equal (result is zero), 2 = not-equal (result non-zero), 3 = greater-or-equal (result bit WIDTH-1 is 0), 4 = signed overflow, 5 = carry.
- R6: Signed overflow is 1 when the exact signed sum or difference lies outside the WIDTH-bit signed range. Carry is bit WIDTH of `in_a + (in_sub ? ~in_b : in_b) + in_sub`, so on subtract it is 1 when no borrow occurs.
- R7: A request with `in_valid`=1, `in_pred_en`=1 and `in_arith_en`=0 gives `out_fault`=1 on the next cycle, with `out_valid` and `out_flag_valid` at 0 and `out_result` unchanged.
- R8: A request with `in_valid`=1, `in_pred_en`=1 and selector 6 or 7 faults the same way, even when `in_arith_en`=1.
- R9: When `in_valid`=0, or when neither `in_arith_en` nor `in_pred_en` is set, no strobe rises on the next cycle and `out_result` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_arith_en | input | 1 | Arithmetic operation present |
| in_sub | input | 1 | 1 = subtract, 0 = add |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_pred_en | input | 1 | Condition test attached |
| in_pred_sel | input | 3 | Condition test selector |
| out_valid | output | 1 | Arithmetic result valid |
| out_result | output | WIDTH | Arithmetic result |
| out_flag_valid | output | 1 | Condition result valid |
| out_flag | output | 1 | Condition result |
| out_fault | output | 1 | Malformed request seen |

## Verification
Every register in the block sits at the output boundary. A wrong carry, overflow or selector decode therefore shows up on `out_flag` in the very cycle after the offending request. A stale or wrongly loaded result register shows up as an `out_result` mismatch at that same point, or on a later idle or faulting cycle when the value should have been held. A bad decode shows up as a mistimed strobe: a fault that wrongly lets `out_valid` through, or a result that wrongly raises `out_flag_valid`. The per-cycle reference comparison catches these within one clock.

// File: rtl/alu_gang_pkg.sv
package alu_gang_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    COND_LT    = 3'd0,
    COND_EQ    = 3'd1,
    COND_NE    = 3'd2,
    COND_GE    = 3'd3,
    COND_OVF   = 3'd4,
    COND_CARRY = 3'd5
  } cond_sel_e;

  localparam logic [SEL_W-1:0] COND_LAST = COND_CARRY;

  function automatic logic sel_is_legal(input logic [SEL_W-1:0] sel);
    return sel <= COND_LAST;
  endfunction

endpackage

// File: rtl/alu_gang_adder.sv
module alu_gang_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    sum   = full[MSB:0];
    carry = full[WIDTH];
    ovf   = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_gang_cond.sv
module alu_gang_cond
  import alu_gang_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] sum,
  input  logic             carry,
  input  logic             ovf,
  input  logic [SEL_W-1:0] sel,
  output logic             flag
);
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero = (sum == '0);
    is_neg  = sum[WIDTH-1];
    unique case (sel)
      COND_LT:    flag = is_neg;
      COND_EQ:    flag = is_zero;
      COND_NE:    flag = !is_zero;
      COND_GE:    flag = !is_neg;
      COND_OVF:   flag = ovf;
      COND_CARRY: flag = carry;
      default:    flag = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_gang_decode.sv
module alu_gang_decode
  import alu_gang_pkg::*;
(
  input  logic             valid,
  input  logic             arith_en,
  input  logic             pred_en,
  input  logic [SEL_W-1:0] sel,
  output logic             take_result,
  output logic             take_flag,
  output logic             fault
);
  logic orphan;
  logic bad_sel;

  always_comb begin
    orphan      = pred_en && !arith_en;
    bad_sel     = pred_en && !sel_is_legal(sel);
    fault       = valid && (orphan || bad_sel);
    take_result = valid && arith_en && !fault;
    take_flag   = take_result && pred_en;
  end
endmodule

// File: rtl/int_alu_gang.sv
module int_alu_gang
  import alu_gang_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_arith_en,
  input  logic             in_sub,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_pred_en,
  input  logic [SEL_W-1:0] in_pred_sel,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_result,
  output logic             out_flag_valid,
  output logic             out_flag,
  output logic             out_fault
);
  logic [WIDTH-1:0] sum;
  logic             carry;
  logic             ovf;
  logic             flag;
  logic             take_result;
  logic             take_flag;
  logic             fault;

  alu_gang_adder #(.WIDTH(WIDTH)) adder_i (
    .a     (in_a),
    .b     (in_b),
    .sub   (in_sub),
    .sum   (sum),
    .carry (carry),
    .ovf   (ovf)
  );

  alu_gang_cond #(.WIDTH(WIDTH)) cond_i (
    .sum   (sum),
    .carry (carry),
    .ovf   (ovf),
    .sel   (in_pred_sel),
    .flag  (flag)
  );

  alu_gang_decode decode_i (
    .valid       (in_valid),
    .arith_en    (in_arith_en),
    .pred_en     (in_pred_en),
    .sel         (in_pred_sel),
    .take_result (take_result),
    .take_flag   (take_flag),
    .fault       (fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_flag_valid <= 1'b0;
      out_flag       <= 1'b0;
      out_fault      <= 1'b0;
      out_result     <= '0;
    end else begin
      out_valid      <= take_result;
      out_flag_valid <= take_flag;
      out_flag       <= take_flag & flag;
      out_fault      <= fault;
      if (take_result) out_result <= sum;
    end
  end

  AST_FLAG_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_flag_valid |-> out_valid); // R4
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_flag_valid |-> !out_flag); // R4
  AST_PLAIN_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_arith_en && !in_pred_en) |=> (out_valid && !out_flag_valid && !out_fault)); // R2
  AST_ORPHAN_FAULT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pred_en && !in_arith_en) |=> (out_fault && !out_valid)); // R7
  AST_BAD_SEL_FAULT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pred_en && (in_pred_sel > COND_LAST)) |=> (out_fault && !out_flag_valid)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && !out_valid && !out_fault)); // R9
  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> (!out_valid && !out_flag_valid)); // R7
endmodule

// File: tb/int_alu_gang_tb_top.sv
`timescale 1ns/1ps
module int_alu_gang_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_arith_en = 1'b0, in_sub = 1'b0, in_pred_en = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [2:0]  in_pred_sel = '0;
  logic        out_valid, out_flag_valid, out_flag, out_fault;
  logic [31:0] out_result;

  always #4 clk = ~clk;

  int_alu_gang #(.WIDTH(32)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_arith_en(in_arith_en),
    .in_sub(in_sub), .in_a(in_a), .in_b(in_b), .in_pred_en(in_pred_en),
    .in_pred_sel(in_pred_sel), .out_valid(out_valid), .out_result(out_result),
    .out_flag_valid(out_flag_valid), .out_flag(out_flag), .out_fault(out_fault)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R1 reset";
  string e_tag = "R1 reset";
  bit    e_valid, e_fval, e_flag, e_fault;
  bit [31:0] e_res;

  // Behavioural reference, one cycle of latency
  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0; e_fval = 0; e_flag = 0; e_fault = 0; e_res = 0;
      e_tag = "R1 reset";
    end else begin
      bit flt, take, cy, ov, f;
      bit [31:0] bx, res;
      longint unsigned u;
      longint sa, sb, ideal;
      flt  = in_valid && in_pred_en && (!in_arith_en || in_pred_sel > 3'd5);
      take = in_valid && in_arith_en && !flt;
      bx   = in_sub ? ~in_b : in_b;
      u    = longint'(in_a) + longint'(bx) + longint'(in_sub);
      res  = u[31:0];
      cy   = u[32];
      sa   = longint'($signed(in_a));
      sb   = longint'($signed(in_b));
      ideal = in_sub ? sa - sb : sa + sb;
      ov   = (ideal > 64'sd2147483647) || (ideal < -64'sd2147483648);
      case (in_pred_sel)
        3'd0: f = res[31];
        3'd1: f = (res == 0);
        3'd2: f = (res != 0);
        3'd3: f = !res[31];
        3'd4: f = ov;
        3'd5: f = cy;
        default: f = 0;
      endcase
      e_valid = take;
      e_fval  = take && in_pred_en;
      e_flag  = e_fval && f;
      e_fault = flt;
      if (take) e_res = res;
      e_tag = cur_tag;
    end
  end

  task automatic check_outputs();
    bit bad = 0;
    n_chk++;
    if (out_valid !== e_valid) begin bad = 1;
      $display("FAIL %s out_valid got %0b exp %0b", e_tag, out_valid, e_valid); end
    if (out_result !== e_res) begin bad = 1;
      $display("FAIL %s out_result got %h exp %h", e_tag, out_result, e_res); end
    if (out_flag_valid !== e_fval) begin bad = 1;
      $display("FAIL %s out_flag_valid got %0b exp %0b", e_tag, out_flag_valid, e_fval); end
    if (out_flag !== e_flag) begin bad = 1;
      $display("FAIL %s out_flag got %0b exp %0b", e_tag, out_flag, e_flag); end
    if (out_fault !== e_fault) begin bad = 1;
      $display("FAIL %s out_fault got %0b exp %0b", e_tag, out_fault, e_fault); end
    if (bad) n_fail++;
  endtask

  task automatic step(input bit v, input bit ar, input bit sb, input bit [31:0] a,
                      input bit [31:0] b, input bit pe, input bit [2:0] sel, input string tag);
    @(negedge clk);
    check_outputs();
    in_valid = v; in_arith_en = ar; in_sub = sb; in_a = a; in_b = b;
    in_pred_en = pe; in_pred_sel = sel; cur_tag = tag;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL all watchdog expired");
    finish_run();
  end

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    check_outputs();
    rst = 0;
    step(0, 0, 0, 0, 0, 0, 0, "R1 after reset");
    step(1, 1, 0, 32'd5, 32'd7, 0, 0, "R2 add");
    step(1, 1, 1, 32'd3, 32'd5, 0, 0, "R2 sub");
    for (int s = 0; s < 6; s++) begin
      step(1, 1, 1, 32'd3, 32'd5, 1, 3'(s), "R3 R5 sub with test");
      step(1, 1, 0, 32'hFFFFFFFF, 32'd1, 1, 3'(s), "R5 R6 add wrap");
      step(1, 1, 1, 32'd9, 32'd9, 1, 3'(s), "R5 equal operands");
      step(1, 1, 0, 32'h7FFFFFFF, 32'd1, 1, 3'(s), "R6 positive overflow");
      step(1, 1, 1, 32'h80000000, 32'd1, 1, 3'(s), "R6 negative overflow");
    end
    step(1, 1, 1, 32'd0, 32'd1, 1, 3'd5, "R6 subtract borrow carry");
    step(1, 1, 1, 32'd1, 32'd0, 1, 3'd5, "R6 subtract no borrow carry");
    step(1, 1, 0, 32'd10, 32'd20, 1, 3'd0, "R4 flag valid");
    step(1, 1, 0, 32'd10, 32'd20, 0, 3'd0, "R4 no flag");
    step(1, 0, 0, 32'd1, 32'd1, 1, 3'd1, "R7 orphan test");
    step(0, 0, 0, 32'd4, 32'd4, 0, 0, "R9 idle hold");
    step(1, 1, 0, 32'd100, 32'd1, 1, 3'd6, "R8 selector 6");
    step(1, 1, 0, 32'd100, 32'd1, 1, 3'd7, "R8 selector 7");
    step(1, 0, 0, 32'd8, 32'd8, 0, 0, "R9 empty request");
    step(0, 1, 0, 32'd8, 32'd8, 1, 0, "R9 valid low");
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 7) != 0, $urandom_range(0, 5) != 0, 1'($urandom),
           $urandom, ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 3)) : $urandom,
           1'($urandom), 3'($urandom), "R3 R5 R8 random");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R9 final idle");
    step(0, 0, 0, 0, 0, 0, 0, "R9 final idle");
    finish_run();
  end
endmodule